// File: doc/BRIEF.md
# Squashable Fetch Instruction Queue

This block is the bounded in-order buffer that sits between instruction fetch and dispatch. Fetch writes an entry at the tail each cycle. An entry holds the instruction word, its PC, a 16-bit sequence number, the number of destination registers it will claim, and a fault flag. Dispatch takes entries from the head. A fetch fault is written as a no-op entry: the word is replaced by a fixed no-op pattern, the destination count is forced to zero and the fault flag is set. Dispatch can therefore pass the fault down the pipe like any other instruction.

When a younger part of the stream turns out to be wrong, a squash request carries the sequence number of the last entry to keep. Starting in the next cycle, the queue drops its youngest entry once per cycle for as long as that entry is younger than the squash number. Each cycle it reports how many destination registers the dropped entry held, so the register free pool can reclaim them. A flush (switch-out) empties the queue at once.

Fetch throttles itself with the occupancy and full outputs. Two running counters, one summing occupancy per cycle and one counting full cycles, give a view of queue pressure.

Top module: `fetch_inst_queue`

## Requirements
- R1: A push is accepted (`pushAccept` high, entry written at the next edge) only when occupancy is below `DEPTH`, no squash phase is active and `flushReq` is low. A pop in the same cycle does not free room for the push. `full` is high exactly when occupancy equals `DEPTH`.
- R2: The head entry is shown on the pop outputs, with `popValid` high whenever the queue is non-empty and no squash phase is active. A cycle with `popReq` and `popValid` both high removes exactly that entry. An empty queue shows `popValid` low.
- R3: Occupancy follows accepted pushes and pops. An accepted push and a pop in the same cycle leave occupancy unchanged.
- R4: A push with `pushFault` high stores the word `NOP_WORD` (default 32'hC000_0000), a destination count of 0 and a fault flag of 1, and keeps the pushed PC and sequence number.
- R5: `popNextPc` always equals `popPc + 4`.
- R6: After a squash request, from the next cycle onward, one tail entry is removed per cycle while the queue is non-empty and the tail's sequence number is greater (unsigned) than the squash number. `squashBusy` is high in exactly those cycles, and older entries are kept in order.
- R7: `relCnt` equals the destination count of the entry removed in that cycle and is 0 in every cycle in which no squash removal happens.
- R8: The squash phase runs from the cycle after the request up to and including the first cycle in which `squashBusy` is low. Throughout that phase, pushes are refused and `popValid` is low.
- R9: `flushReq` empties the queue at the next edge, ends any squash phase and refuses a push in the same cycle.
- R10: At every clock edge after reset, `occSum` grows by the occupancy of the cycle that ends, and `fullCycles` grows by 1 when that cycle was full.
- R11: After reset the queue is empty: occupancy 0, `full` 0, `popValid` 0, `squashBusy` 0, both counters 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flushReq | input | 1 | Switch-out: empty the queue |
| pushValid | input | 1 | Fetch offers an entry |
| pushFault | input | 1 | Offered entry is a fetch fault |
| pushWord | input | 32 | Instruction word |
| pushPc | input | 32 | Instruction PC |
| pushSeq | input | 16 | Sequence number |
| pushDstCnt | input | 2 | Destination register count |
| pushAccept | output | 1 | Offered entry is taken this cycle |
| popReq | input | 1 | Dispatch takes the head entry |
| popValid | output | 1 | Head entry is available |
| popWord | output | 32 | Head instruction word |
| popPc | output | 32 | Head PC |
| popNextPc | output | 32 | Head PC plus 4 |
| popSeq | output | 16 | Head sequence number |
| popDstCnt | output | 2 | Head destination count |
| popFault | output | 1 | Head is a fault carrier |
| squashReq | input | 1 | Start a tail squash |
| squashSeq | input | 16 | Youngest sequence number to keep |
| squashBusy | output | 1 | An entry is being removed this cycle |
| relCnt | output | 2 | Registers released this cycle |
| occupancy | output | 4 | Entries held |
| full | output | 1 | Occupancy equals DEPTH |
| occSum | output | 32 | Accumulated occupancy |
| fullCycles | output | 32 | Number of full cycles |

## Verification
Every cycle, the embedded assertions check the occupancy bound and that a full queue never accepts. They also check that simultaneous push and pop hold occupancy, that each squash removal lowers occupancy by exactly one, that flush empties the queue, the counter growth, and the shape of a stored fault entry. Only the scoreboard scenarios can show the order and content of what dispatch receives. The same holds for which entries a squash keeps and the release count of each removed entry, and for pushes and pops being shut out for the whole squash phase.

// File: rtl/fiq_pkg.sv
`timescale 1ns/1ps
package fiq_pkg;
  localparam int WORD_W = 32;
  localparam int PC_W   = 32;
  localparam int SEQ_W  = 16;
  localparam int DC_W   = 2;

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [PC_W-1:0]   pc;
    logic [SEQ_W-1:0]  seq;
    logic [DC_W-1:0]   dstCnt;
    logic              fault;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic drop;
    logic flush;
  } strobe_t;
endpackage

// File: rtl/fiq_store.sv
`timescale 1ns/1ps
module fiq_store import fiq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter logic [WORD_W-1:0] NOP_WORD = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic              pushFault,
  input  logic [WORD_W-1:0] pushWord,
  input  logic [PC_W-1:0]   pushPc,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [DC_W-1:0]   pushDstCnt,
  output entry_t            headEnt,
  output entry_t            lastEnt
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  entry_t mem [DEPTH];
  logic [IDX_W-1:0] headPtr, tailPtr;
  entry_t newEnt;

  function automatic logic [IDX_W-1:0] stepUp(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] stepDown(input logic [IDX_W-1:0] i);
    return (i == '0) ? LAST_IDX : i - 1'b1;
  endfunction

  always_comb begin
    newEnt.pc  = pushPc;
    newEnt.seq = pushSeq;
    if (pushFault) begin
      newEnt.word   = NOP_WORD;
      newEnt.dstCnt = '0;
      newEnt.fault  = 1'b1;
    end else begin
      newEnt.word   = pushWord;
      newEnt.dstCnt = pushDstCnt;
      newEnt.fault  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push && !strobe.flush) mem[tailPtr] <= newEnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (strobe.pop)       headPtr <= stepUp(headPtr);
      if (strobe.drop)      tailPtr <= stepDown(tailPtr);
      else if (strobe.push) tailPtr <= stepUp(tailPtr);
    end
  end

  assign headEnt = mem[headPtr];
  assign lastEnt = mem[stepDown(tailPtr)];

  // R8: removal never shares a cycle with a push or a pop
  a_r8_drop_alone: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |-> (!strobe.push && !strobe.pop));

  // R4: a fault push lands at the tail as a no-op carrier
  a_r4_fault_nop: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.flush && pushFault) |=>
      (lastEnt.fault && lastEnt.word == NOP_WORD && lastEnt.dstCnt == '0));
endmodule

// File: rtl/fiq_ctrl.sv
`timescale 1ns/1ps
module fiq_ctrl import fiq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int ACC_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flushReq,
  input  logic             pushValid,
  input  logic             popReq,
  input  logic             squashReq,
  input  logic [SEQ_W-1:0] squashSeq,
  input  logic [SEQ_W-1:0] lastSeq,
  input  logic [DC_W-1:0]  lastDstCnt,
  output strobe_t          strobe,
  output logic             pushAccept,
  output logic             popValid,
  output logic             squashBusy,
  output logic [DC_W-1:0]  relCnt,
  output logic [CNT_W-1:0] occupancy,
  output logic             full,
  output logic [ACC_W-1:0] occSum,
  output logic [ACC_W-1:0] fullCycles
);
  logic [CNT_W-1:0] count;
  logic             squashing;
  logic [SEQ_W-1:0] keepSeq;
  logic             dropNow;

  assign full       = (count == CNT_W'(DEPTH));
  assign dropNow    = squashing && (count != '0) && (lastSeq > keepSeq) && !flushReq;
  assign pushAccept = pushValid && !full && !squashing && !flushReq;
  assign popValid   = (count != '0) && !squashing;

  always_comb begin
    strobe.push  = pushAccept;
    strobe.pop   = popReq && popValid && !flushReq;
    strobe.drop  = dropNow;
    strobe.flush = flushReq;
  end

  assign squashBusy = dropNow;
  assign relCnt     = dropNow ? lastDstCnt : '0;
  assign occupancy  = count;

  always_ff @(posedge clk) begin
    if (!rstN || flushReq) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(strobe.push) - CNT_W'(strobe.pop) - CNT_W'(strobe.drop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || flushReq) begin
      squashing <= 1'b0;
      keepSeq   <= '0;
    end else if (squashReq) begin
      squashing <= 1'b1;
      keepSeq   <= squashSeq;
    end else if (squashing && !dropNow) begin
      squashing <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occSum     <= '0;
      fullCycles <= '0;
    end else begin
      occSum     <= occSum + ACC_W'(count);
      fullCycles <= fullCycles + ACC_W'(full);
    end
  end

  a_r1_bounded: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  a_r1_full_refuses: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !pushAccept);

  a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.pop && !flushReq) |=> (count == $past(count)));

  a_r6_one_per_cycle: assert property (@(posedge clk) disable iff (!rstN)
    strobe.drop |=> (count == $past(count) - CNT_W'(1)));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flushReq |=> (count == '0 && !squashing));

  a_r10_accumulate: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (occSum == $past(occSum) + ACC_W'($past(count))));
endmodule

// File: rtl/fetch_inst_queue.sv
`timescale 1ns/1ps
module fetch_inst_queue import fiq_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int ACC_W = 32,
  parameter logic [WORD_W-1:0] NOP_WORD = 32'hC000_0000,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flushReq,
  input  logic              pushValid,
  input  logic              pushFault,
  input  logic [WORD_W-1:0] pushWord,
  input  logic [PC_W-1:0]   pushPc,
  input  logic [SEQ_W-1:0]  pushSeq,
  input  logic [DC_W-1:0]   pushDstCnt,
  output logic              pushAccept,
  input  logic              popReq,
  output logic              popValid,
  output logic [WORD_W-1:0] popWord,
  output logic [PC_W-1:0]   popPc,
  output logic [PC_W-1:0]   popNextPc,
  output logic [SEQ_W-1:0]  popSeq,
  output logic [DC_W-1:0]   popDstCnt,
  output logic              popFault,
  input  logic              squashReq,
  input  logic [SEQ_W-1:0]  squashSeq,
  output logic              squashBusy,
  output logic [DC_W-1:0]   relCnt,
  output logic [CNT_W-1:0]  occupancy,
  output logic              full,
  output logic [ACC_W-1:0]  occSum,
  output logic [ACC_W-1:0]  fullCycles
);
  strobe_t strobe;
  entry_t  headEnt, lastEnt;

  fiq_ctrl #(.DEPTH(DEPTH), .ACC_W(ACC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .pushValid(pushValid),
    .popReq(popReq), .squashReq(squashReq), .squashSeq(squashSeq),
    .lastSeq(lastEnt.seq), .lastDstCnt(lastEnt.dstCnt), .strobe(strobe),
    .pushAccept(pushAccept), .popValid(popValid), .squashBusy(squashBusy),
    .relCnt(relCnt), .occupancy(occupancy), .full(full), .occSum(occSum),
    .fullCycles(fullCycles)
  );

  fiq_store #(.DEPTH(DEPTH), .NOP_WORD(NOP_WORD)) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushFault(pushFault),
    .pushWord(pushWord), .pushPc(pushPc), .pushSeq(pushSeq),
    .pushDstCnt(pushDstCnt), .headEnt(headEnt), .lastEnt(lastEnt)
  );

  assign popWord   = headEnt.word;
  assign popPc     = headEnt.pc;
  assign popNextPc = headEnt.pc + PC_W'(4);
  assign popSeq    = headEnt.seq;
  assign popDstCnt = headEnt.dstCnt;
  assign popFault  = headEnt.fault;
endmodule

// File: tb/fetch_inst_queue_tb_top.sv
`timescale 1ns/1ps
module fetch_inst_queue_tb_top;
  import fiq_pkg::*;
  localparam int DEPTH = 8;
  localparam logic [31:0] NOP = 32'hC000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flushReq = 0, pushValid = 0, pushFault = 0, popReq = 0, squashReq = 0;
  logic [31:0] pushWord = '0, pushPc = '0;
  logic [15:0] pushSeq = '0, squashSeq = '0;
  logic [1:0]  pushDstCnt = '0;
  logic pushAccept, popValid, popFault, squashBusy, full;
  logic [31:0] popWord, popPc, popNextPc, occSum, fullCycles;
  logic [15:0] popSeq;
  logic [1:0]  popDstCnt, relCnt;
  logic [3:0]  occupancy;

  always #10 clk = ~clk;  // 50 MHz

  fetch_inst_queue dut_i (
    .clk(clk), .rstN(rstN), .flushReq(flushReq), .pushValid(pushValid),
    .pushFault(pushFault), .pushWord(pushWord), .pushPc(pushPc),
    .pushSeq(pushSeq), .pushDstCnt(pushDstCnt), .pushAccept(pushAccept),
    .popReq(popReq), .popValid(popValid), .popWord(popWord), .popPc(popPc),
    .popNextPc(popNextPc), .popSeq(popSeq), .popDstCnt(popDstCnt),
    .popFault(popFault), .squashReq(squashReq), .squashSeq(squashSeq),
    .squashBusy(squashBusy), .relCnt(relCnt), .occupancy(occupancy),
    .full(full), .occSum(occSum), .fullCycles(fullCycles)
  );

  entry_t expQ[$];
  int total = 0, bad = 0;
  longint expOcc = 0, expFull = 0;
  bit inSquash = 0;
  logic [15:0] keepM = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // inputs change 2 ns after a rising edge; combinational checks at +7
  task automatic cycleStart();
    @(posedge clk);
    #2;
    pushValid = 0; pushFault = 0; popReq = 0; squashReq = 0; flushReq = 0;
    chk(occupancy == expQ.size(), "R3", "occupancy", occupancy, expQ.size());
    chk(full == (expQ.size() == DEPTH), "R1", "full", full, expQ.size() == DEPTH);
  endtask

  task automatic doPush(input logic [15:0] seq, input bit isFault, input bit withPop);
    bit expAcc;
    entry_t e;
    cycleStart();
    pushValid = 1; pushFault = isFault;
    pushWord = 32'hA500_0000 | 32'(seq);
    pushPc = 32'h0000_4000 + {14'd0, seq, 2'b00};
    pushSeq = seq; pushDstCnt = seq[1:0]; popReq = withPop;
    expAcc = (expQ.size() < DEPTH) && !inSquash;
    #5;
    chk(pushAccept == expAcc, inSquash ? "R8" : "R1", "pushAccept", pushAccept, expAcc);
    #5;
    if (expAcc) begin
      e.word = isFault ? NOP : pushWord;
      e.pc = pushPc; e.seq = seq;
      e.dstCnt = isFault ? 2'd0 : seq[1:0];
      e.fault = isFault;
      expQ.push_back(e);
    end
  endtask

  task automatic doPop();
    bit expV;
    cycleStart();
    popReq = 1;
    expV = (expQ.size() != 0) && !inSquash;
    #5;
    chk(popValid == expV, "R2", "popValid", popValid, expV);
    #5;
  endtask

  task automatic doIdle();
    cycleStart();
    #10;
  endtask

  task automatic doFlush(input bit withPush);
    cycleStart();
    flushReq = 1; pushValid = withPush;
    #5;
    chk(pushAccept == 0, "R9", "pushAccept during flush", pushAccept, 0);
    #5;
    expQ.delete();
    inSquash = 0;
  endtask

  task automatic doSquash(input logic [15:0] seq);
    cycleStart();
    squashReq = 1; squashSeq = seq;
    #10;
    keepM = seq;
    inSquash = 1;
  endtask

  task automatic squashWatch(input bit tryAccess, output bit busy);
    bit expBusy;
    logic [1:0] expRel;
    cycleStart();
    if (tryAccess) begin
      pushValid = 1; pushSeq = 16'hFFFF; popReq = 1;
    end
    expBusy = (expQ.size() > 0) && (expQ[$].seq > keepM);
    expRel = expBusy ? expQ[$].dstCnt : 2'd0;
    #5;
    chk(squashBusy == expBusy, "R6", "squashBusy", squashBusy, expBusy);
    chk(relCnt == expRel, "R7", "relCnt", relCnt, expRel);
    chk(popValid == 0, "R8", "popValid in squash", popValid, 0);
    if (tryAccess) chk(pushAccept == 0, "R8", "pushAccept in squash", pushAccept, 0);
    #5;
    if (expBusy) void'(expQ.pop_back());
    else inSquash = 0;
    busy = expBusy;
  endtask

  task automatic runSquash(input logic [15:0] seq);
    bit b;
    doSquash(seq);
    for (int i = 0; i < DEPTH + 2; i++) begin
      squashWatch(i[0] == 1'b0, b);
      if (!b) break;
    end
  endtask

  task automatic checkCounters();
    cycleStart();
    #5;
    chk(occSum == 32'(expOcc), "R10", "occSum", occSum, expOcc);
    chk(fullCycles == 32'(expFull), "R10", "fullCycles", fullCycles, expFull);
    #5;
  endtask

  // monitor: mid-cycle, consumes scoreboard entries as dispatch pops them
  always @(negedge clk) begin : monitor
    entry_t e;
    if (rstN) begin
      expOcc += expQ.size();
      if (expQ.size() == DEPTH) expFull++;
      if (popReq && popValid && !flushReq) begin
        if (expQ.size() == 0) begin
          chk(0, "R2", "pop from empty", 1, 0);
        end else begin
          e = expQ.pop_front();
          chk(popSeq == e.seq, "R2", "popSeq", popSeq, e.seq);
          chk(popWord == e.word, e.fault ? "R4" : "R2", "popWord", popWord, e.word);
          chk(popPc == e.pc, "R2", "popPc", popPc, e.pc);
          chk(popDstCnt == e.dstCnt, e.fault ? "R4" : "R2", "popDstCnt", popDstCnt, e.dstCnt);
          chk(popFault == e.fault, "R4", "popFault", popFault, e.fault);
          chk(popNextPc == e.pc + 32'd4, "R5", "popNextPc", popNextPc, e.pc + 32'd4);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    chk(0, "watchdog", "run did not finish", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    #5;
    // R11 reset state
    chk(occupancy == 0, "R11", "occupancy", occupancy, 0);
    chk(full == 0, "R11", "full", full, 0);
    chk(popValid == 0, "R11", "popValid", popValid, 0);
    chk(squashBusy == 0, "R11", "squashBusy", squashBusy, 0);
    chk(occSum == 0 && fullCycles == 0, "R11", "counters", occSum, 0);

    for (int s = 1; s <= DEPTH; s++) doPush(16'(s), s == 3, 1'b0);
    doPush(16'd9, 1'b0, 1'b0);            // R1: refused while full
    doPush(16'd9, 1'b0, 1'b1);            // R1: pop does not make room this cycle
    doPop();
    doPush(16'd10, 1'b0, 1'b1);           // R3: push+pop, pops the fault entry (R4)
    doPush(16'd11, 1'b0, 1'b1);           // R3
    doIdle();
    runSquash(16'd7);                     // R6/R7/R8: drops 11, 10, 8
    doIdle();
    runSquash(16'd20);                    // R6: nothing younger, nothing dropped
    doPush(16'd12, 1'b0, 1'b0);
    checkCounters();                      // R10
    for (int i = 0; i < 5; i++) doPop();  // drains, last pop sees empty (R2)
    doPush(16'd13, 1'b1, 1'b0);
    doPush(16'd14, 1'b0, 1'b0);
    doPush(16'd15, 1'b0, 1'b0);
    runSquash(16'd13);                    // R6: drops 15, 14; keeps fault entry
    doPush(16'd16, 1'b0, 1'b0);
    doFlush(1'b1);                        // R9
    doIdle();
    doPop();                              // R9: nothing left
    checkCounters();                      // R10
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule